// File: doc/BRIEF.md
# Shared-Table Harmonic Additive Synthesizer

This block produces a single timbre as a running sum of sixteen sinusoidal partials. Each partial owns a programmable clock divider and a 6-bit phase counter, and all sixteen run side by side. They do not each own a sine table or a multiplier. Whenever a partial's phase moves on, it raises a request. A small controller then serves the pending requests one at a time. For each one it looks up the sine sample, scales it by the partial's gain, keeps the product in that partial's slot and refreshes the total.

Software, or a neighbouring block, sets each partial's divide factor and signed gain through a one-word write port. The downstream logic takes the signed total together with a one-cycle strobe that names the partial just refreshed. Envelope, volume, mixing with other timbres and the serial audio link belong to other blocks.

Top module: `harmonic_synth`

## Requirements
- R1: A synchronous reset (`rst` high) clears every divider, phase counter, request, product slot, divide factor and gain. While reset is held and after it is released, `sum_out` is 0 and `out_valid` is 0.
- R2: A write is made with `cfg_we` high for one clock. `cfg_sel` = 0 stores `cfg_data` as the divide factor of partial `cfg_ch`, and `cfg_sel` = 1 stores it as that partial's 16-bit two's-complement gain. Partials are numbered 0 (fundamental) to 15.
- R3: A partial with divide factor D > 0 advances its phase once every D clocks. When it is the only active partial, its refreshes appear on `out_valid` exactly D clocks apart.
- R4: The phase is 6 bits wide, advances by one per step and wraps from 63 to 0. After reset, the first refresh of a partial uses phase 1, and its n-th refresh uses phase n mod 64.
- R5: Sine table entry k (0 to 63) equals 32767·sin(2πk/64) rounded to the nearest integer, with halves rounded away from zero.
- R6: A refresh stores the 32-bit signed product of the table entry at the partial's current phase and the partial's gain into that partial's slot.
- R7: In the cycle where `out_valid` is high, `out_ch` names the refreshed partial and `sum_out` equals the 36-bit signed sum of all sixteen slots. With extreme gains this sum does not overflow.
- R8: A request stays pending until it is served and is then cleared. For divide factors of 80 or more, every phase step is served exactly once.
- R9: When several requests are pending, the partial with the lowest index is served first.
- R10: Each calculation takes four clocks (grant, table read, multiply, slot write with sum update), so `out_valid` pulses are at least four clocks apart.
- R11: A divide factor of 0 stops that partial. It raises no further requests, and `sum_out` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = divide factor, 1 = gain |
| cfg_ch | input | 4 | Partial index for the write |
| cfg_data | input | 16 | Write data |
| sum_out | output | 36 | Signed sum of all partial slots |
| out_valid | output | 1 | One-cycle strobe on each slot refresh |
| out_ch | output | 4 | Partial refreshed when `out_valid` is high |

## Verification
A corrupted phase counter or sine entry shows up at the very next strobe of that partial: `sum_out` moves by the wrong amount, up to one divide period after the fault. A lost or duplicated request appears as a missing or extra strobe for that index, so the spacing of strobes drifts from D or the per-partial counts disagree. A broken arbiter puts the strobes of a crowded burst in the wrong index order within a few calculation cycles. A running total that has drifted from the slots gives the wrong `sum_out` on every strobe that follows.

// File: rtl/harm_pkg.sv
package harm_pkg;

    typedef enum logic [1:0] {
        CALC_GRANT = 2'd0,
        CALC_READ  = 2'd1,
        CALC_MUL   = 2'd2,
        CALC_WRITE = 2'd3
    } calc_state_e;

    localparam int     FX_FRAC = 30;
    localparam longint FX_HALF = longint'(1) <<< (FX_FRAC - 1);
    localparam longint FX_PI   = 64'sd3373259426;

    // sin(pi/2 * j / qsteps) in Q30, Taylor series
    function automatic longint fx_sin_quarter(input int j, input int qsteps);
        longint x;
        longint x2;
        longint term;
        longint acc;
        x    = (FX_PI * longint'(j)) / longint'(2 * qsteps);
        x2   = (x * x) >>> FX_FRAC;
        term = x;
        acc  = x;
        for (int n = 1; n < 12; n++) begin
            term = -((term * x2) >>> FX_FRAC) / longint'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // rounded amp * sin(2*pi*k/points)
    function automatic int sine_entry(input int k, input int points, input int amp);
        int     q;
        longint s;
        longint sc;
        q = points / 4;
        if (k <= q)           s = fx_sin_quarter(k, q);
        else if (k <= 2 * q)  s = fx_sin_quarter(2 * q - k, q);
        else if (k <= 3 * q)  s = -fx_sin_quarter(k - 2 * q, q);
        else                  s = -fx_sin_quarter(points - k, q);
        sc = s * longint'(amp);
        if (sc >= 0) return int'((sc + FX_HALF) >>> FX_FRAC);
        return -int'(((-sc) + FX_HALF) >>> FX_FRAC);
    endfunction

endpackage

// File: rtl/harm_channel.sv
module harm_channel #(
    parameter int DIV_W  = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              div_we,
    input  logic [DIV_W-1:0]  div_wdata,
    input  logic              clr,
    output logic              req,
    output logic [ADDR_W-1:0] phase
);

    typedef struct packed {
        logic [DIV_W-1:0]  div;
        logic [DIV_W-1:0]  cnt;
        logic [ADDR_W-1:0] phase;
        logic              req;
    } chan_s;

    chan_s st_d, st_q;
    logic  tick;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (div_we) begin
            st_d.div = div_wdata;
        end
        if (st_q.div == '0) begin
            st_d.cnt = '0;
        end else if (st_q.cnt >= st_q.div - DIV_W'(1)) begin
            st_d.cnt = '0;
            tick     = 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + DIV_W'(1);
        end
        if (tick) begin
            st_d.phase = st_q.phase + ADDR_W'(1);
            st_d.req   = 1'b1;
        end else if (clr) begin
            st_d.req = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req   = st_q.req;
    assign phase = st_q.phase;

    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (st_q.req && !clr) |=> st_q.req); // R8

    AST_PHASE_STEP: assert property (@(posedge clk) disable iff (rst)
        (st_q.phase != $past(st_q.phase)) |-> (st_q.phase == $past(st_q.phase) + ADDR_W'(1))); // R4

    AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (st_q.div == '0) |=> $stable(st_q.phase)); // R11

endmodule

// File: rtl/harm_arbiter.sv
module harm_arbiter #(
    parameter int  NUM_CH = 16,
    localparam int IDX_W  = $clog2(NUM_CH)
) (
    input  logic [NUM_CH-1:0] req,
    output logic              gnt_valid,
    output logic [IDX_W-1:0]  gnt_idx
);

    always_comb begin
        gnt_valid = |req;
        gnt_idx   = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/harm_sine_rom.sv
module harm_sine_rom #(
    parameter int ADDR_W = 6,
    parameter int SAMP_W = 16,
    parameter int AMP    = 32767
) (
    input  logic [ADDR_W-1:0]        addr,
    output logic signed [SAMP_W-1:0] data
);

    localparam int POINTS = 1 << ADDR_W;

    logic signed [SAMP_W-1:0] table_w [POINTS];

    for (genvar k = 0; k < POINTS; k++) begin : g_entry
        localparam int VAL = harm_pkg::sine_entry(k, POINTS, AMP);
        assign table_w[k] = SAMP_W'(VAL);
    end

    assign data = table_w[addr];

endmodule

// File: rtl/harm_calc.sv
module harm_calc
    import harm_pkg::*;
#(
    parameter int  NUM_CH = 16,
    parameter int  ADDR_W = 6,
    parameter int  SAMP_W = 16,
    parameter int  COEF_W = 16,
    parameter int  SUM_W  = 36,
    localparam int IDX_W  = $clog2(NUM_CH),
    localparam int PROD_W = SAMP_W + COEF_W
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     coef_we,
    input  logic [IDX_W-1:0]         coef_idx,
    input  logic [COEF_W-1:0]        coef_wdata,
    input  logic                     gnt_valid,
    input  logic [IDX_W-1:0]         gnt_idx,
    input  logic [ADDR_W-1:0]        phase [NUM_CH],
    output logic [ADDR_W-1:0]        rom_addr,
    input  logic signed [SAMP_W-1:0] rom_data,
    output logic [NUM_CH-1:0]        clr,
    output logic signed [SUM_W-1:0]  sum_out,
    output logic                     out_valid,
    output logic [IDX_W-1:0]         out_ch
);

    typedef struct packed {
        calc_state_e        state;
        logic [IDX_W-1:0]   sel;
        logic [SAMP_W-1:0]  samp;
        logic [COEF_W-1:0]  coef;
        logic [PROD_W-1:0]  prod;
        logic [SUM_W-1:0]   sum;
        logic               valid;
    } calc_s;

    calc_s cs_d, cs_q;

    logic signed [PROD_W-1:0] buf_d  [NUM_CH];
    logic signed [PROD_W-1:0] buf_q  [NUM_CH];
    logic signed [COEF_W-1:0] coef_d [NUM_CH];
    logic signed [COEF_W-1:0] coef_q [NUM_CH];
    logic signed [SUM_W-1:0]  buf_total;

    always_comb begin
        cs_d       = cs_q;
        cs_d.valid = 1'b0;
        buf_d      = buf_q;
        coef_d     = coef_q;
        clr        = '0;
        rom_addr   = phase[cs_q.sel];
        if (coef_we) begin
            coef_d[coef_idx] = coef_wdata;
        end
        case (cs_q.state)
            CALC_GRANT: begin
                if (gnt_valid) begin
                    cs_d.sel   = gnt_idx;
                    cs_d.state = CALC_READ;
                end
            end
            CALC_READ: begin
                cs_d.samp  = rom_data;
                cs_d.coef  = coef_q[cs_q.sel];
                cs_d.state = CALC_MUL;
            end
            CALC_MUL: begin
                cs_d.prod  = $signed(cs_q.samp) * $signed(cs_q.coef);
                cs_d.state = CALC_WRITE;
            end
            default: begin
                buf_d[cs_q.sel] = $signed(cs_q.prod);
                cs_d.sum        = $signed(cs_q.sum)
                                - SUM_W'(buf_q[cs_q.sel])
                                + SUM_W'($signed(cs_q.prod));
                clr[cs_q.sel]   = 1'b1;
                cs_d.valid      = 1'b1;
                cs_d.state      = CALC_GRANT;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q   <= '0;
            buf_q  <= '{default: '0};
            coef_q <= '{default: '0};
        end else begin
            cs_q   <= cs_d;
            buf_q  <= buf_d;
            coef_q <= coef_d;
        end
    end

    assign sum_out   = $signed(cs_q.sum);
    assign out_valid = cs_q.valid;
    assign out_ch    = cs_q.sel;

    always_comb begin
        buf_total = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            buf_total = buf_total + SUM_W'(buf_q[i]);
        end
    end

    AST_SUM_MATCH: assert property (@(posedge clk) disable iff (rst)
        (cs_q.state == CALC_GRANT) |-> ($signed(cs_q.sum) == buf_total)); // R7

    AST_VALID_GAP: assert property (@(posedge clk) disable iff (rst)
        cs_q.valid |=> !cs_q.valid); // R10

    AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $onehot0(clr)); // R10

endmodule

// File: rtl/harmonic_synth.sv
module harmonic_synth #(
    parameter int  NUM_CH   = 16,
    parameter int  DIV_W    = 16,
    parameter int  ADDR_W   = 6,
    parameter int  SAMP_W   = 16,
    parameter int  COEF_W   = 16,
    parameter int  SUM_W    = 36,
    parameter int  SINE_AMP = 32767,
    localparam int IDX_W    = $clog2(NUM_CH),
    localparam int CFG_W    = (DIV_W > COEF_W) ? DIV_W : COEF_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic                    cfg_sel,
    input  logic [IDX_W-1:0]        cfg_ch,
    input  logic [CFG_W-1:0]        cfg_data,
    output logic signed [SUM_W-1:0] sum_out,
    output logic                    out_valid,
    output logic [IDX_W-1:0]        out_ch
);

    logic [NUM_CH-1:0]        req_vec;
    logic [NUM_CH-1:0]        clr_vec;
    logic [ADDR_W-1:0]        phase_arr [NUM_CH];
    logic                     gnt_valid;
    logic [IDX_W-1:0]         gnt_idx;
    logic [ADDR_W-1:0]        rom_addr;
    logic signed [SAMP_W-1:0] rom_data;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        harm_channel #(
            .DIV_W (DIV_W),
            .ADDR_W(ADDR_W)
        ) u_ch (
            .clk      (clk),
            .rst      (rst),
            .div_we   (cfg_we && !cfg_sel && (cfg_ch == IDX_W'(c))),
            .div_wdata(cfg_data[DIV_W-1:0]),
            .clr      (clr_vec[c]),
            .req      (req_vec[c]),
            .phase    (phase_arr[c])
        );
    end

    harm_arbiter #(
        .NUM_CH(NUM_CH)
    ) u_arb (
        .req      (req_vec),
        .gnt_valid(gnt_valid),
        .gnt_idx  (gnt_idx)
    );

    harm_sine_rom #(
        .ADDR_W(ADDR_W),
        .SAMP_W(SAMP_W),
        .AMP   (SINE_AMP)
    ) u_rom (
        .addr(rom_addr),
        .data(rom_data)
    );

    harm_calc #(
        .NUM_CH(NUM_CH),
        .ADDR_W(ADDR_W),
        .SAMP_W(SAMP_W),
        .COEF_W(COEF_W),
        .SUM_W (SUM_W)
    ) u_calc (
        .clk       (clk),
        .rst       (rst),
        .coef_we   (cfg_we && cfg_sel),
        .coef_idx  (cfg_ch),
        .coef_wdata(cfg_data[COEF_W-1:0]),
        .gnt_valid (gnt_valid),
        .gnt_idx   (gnt_idx),
        .phase     (phase_arr),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data),
        .clr       (clr_vec),
        .sum_out   (sum_out),
        .out_valid (out_valid),
        .out_ch    (out_ch)
    );

    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> ((req_vec & ((NUM_CH'(1) << gnt_idx) - NUM_CH'(1))) == '0)); // R9

    AST_GRANT_PENDING: assert property (@(posedge clk) disable iff (rst)
        gnt_valid |-> req_vec[gnt_idx]); // R8

    AST_CLEAR_PENDING: assert property (@(posedge clk) disable iff (rst)
        (|clr_vec) |-> ((clr_vec & req_vec) == clr_vec)); // R8

endmodule

// File: tb/harmonic_synth_tb.sv
`timescale 1ns/1ps
module harmonic_synth_tb;

    localparam int NCH = 16;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cfg_we = 1'b0;
    logic               cfg_sel = 1'b0;
    logic [3:0]         cfg_ch = '0;
    logic [15:0]        cfg_data = '0;
    logic signed [35:0] sum_out;
    logic               out_valid;
    logic [3:0]         out_ch;

    int     checks = 0;
    int     errors = 0;
    longint cyc = 0;

    typedef struct {
        int     ch;
        longint sum;
    } exp_t;

    exp_t   exp_q [$];
    longint sine_ref [64];
    longint coef_m [NCH];
    longint buf_m  [NCH];
    int     svc_n  [NCH];
    longint last_t [NCH];
    longint last_any = -1;
    int     gap_ch = -1;
    longint gap_exp = 0;
    int     seq [16];
    int     seq_len = 0;
    int     valid_count = 0;

    harmonic_synth u_dut (
        .clk      (clk),
        .rst      (rst),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_ch   (cfg_ch),
        .cfg_data (cfg_data),
        .sum_out  (sum_out),
        .out_valid(out_valid),
        .out_ch   (out_ch)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic longint ref_sample(int k);
        real v;
        v = 32767.0 * $sin(2.0 * 3.14159265358979323846 * k / 64.0);
        if (v >= 0.0) return longint'($rtoi($floor(v + 0.5)));
        return -longint'($rtoi($floor(-v + 0.5)));
    endfunction

    task automatic check(bit ok, string req, longint act, longint exp, string what);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    task automatic clear_model();
        exp_q.delete();
        for (int c = 0; c < NCH; c++) begin
            coef_m[c] = 0;
            buf_m[c]  = 0;
            svc_n[c]  = 0;
            last_t[c] = -1;
        end
        last_any = -1;
        gap_ch   = -1;
        seq_len  = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        clear_model();
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic cfg_write(bit sel, int ch, int data);
        @(negedge clk);
        cfg_we   = 1'b1;
        cfg_sel  = sel;
        cfg_ch   = 4'(ch);
        cfg_data = 16'(data);
        if (sel) coef_m[ch] = longint'(shortint'(data));
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // driver: expected refreshes of one lone partial
    task automatic expect_lone(int ch, int count, longint gain);
        exp_t e;
        for (int n = 1; n <= count; n++) begin
            e.ch  = ch;
            e.sum = sine_ref[n % 64] * gain;
            exp_q.push_back(e);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            int     c;
            longint tot;
            exp_t   e;
            c = int'(out_ch);
            valid_count++;
            svc_n[c]++;
            buf_m[c] = sine_ref[svc_n[c] % 64] * coef_m[c];
            tot = 0;
            for (int i = 0; i < NCH; i++) tot += buf_m[i];
            if (exp_q.size() > 0) begin
                e = exp_q.pop_front();
                check(c == e.ch, "R4", c, e.ch, "refreshed partial");
                check(longint'(sum_out) == e.sum, "R6", sum_out, e.sum, "R5 table times gain");
            end else begin
                check(longint'(sum_out) == tot, "R7", sum_out, tot, "sum of slots");
            end
            if (last_any >= 0)
                check((cyc - last_any) >= 4, "R10", cyc - last_any, 4, "strobe spacing");
            if (gap_ch == c && last_t[c] >= 0)
                check((cyc - last_t[c]) == gap_exp, "R3", cyc - last_t[c], gap_exp, "refresh period");
            last_t[c] = cyc;
            last_any  = cyc;
            if (seq_len < 16) begin
                seq[seq_len] = c;
                seq_len++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        finish_run();
    end

    initial begin
        longint held;
        int     vc;
        int     mn;
        int     mx;
        bit     incr;
        bit     distinct;
        for (int k = 0; k < 64; k++) sine_ref[k] = ref_sample(k);

        // R1: reset state
        do_reset();
        check(sum_out == 0, "R1", sum_out, 0, "sum after reset");
        check(out_valid == 1'b0, "R1", out_valid, 0, "strobe after reset");
        vc = valid_count;
        repeat (200) @(negedge clk);
        check(valid_count == vc, "R11", valid_count - vc, 0, "no strobes with all partials off");

        // R2 R3 R4 R5 R6: one partial alone, through phase wrap
        cfg_write(1'b1, 3, 1000);
        gap_ch  = 3;
        gap_exp = 64;
        expect_lone(3, 70, 1000);
        cfg_write(1'b0, 3, 64);
        while (exp_q.size() > 0) @(negedge clk);
        check(svc_n[3] == 70, "R8", svc_n[3], 70, "lone refresh count");

        // R11: stop the partial
        cfg_write(1'b0, 3, 0);
        held = longint'(sum_out);
        vc   = valid_count;
        repeat (300) @(negedge clk);
        check(valid_count == vc, "R11", valid_count - vc, 0, "strobes after divide 0");
        check(longint'(sum_out) == held, "R11", sum_out, held, "sum held after divide 0");

        // R1: reset from a non-zero total
        check(held != 0, "R1", held, 1, "total nonzero before reset");
        do_reset();
        check(sum_out == 0, "R1", sum_out, 0, "sum after mid-run reset");

        // R7 R8 R9: all partials, extreme gains, staggered start from the top index
        for (int c = 0; c < NCH; c++) cfg_write(1'b1, c, (c % 2 == 0) ? 32767 : -32768);
        for (int c = NCH - 1; c >= 0; c--) cfg_write(1'b0, c, 80);
        repeat (2400) @(negedge clk);

        check(seq_len == 16, "R9", seq_len, 16, "burst length");
        check(seq[0] == 15, "R9", seq[0], 15, "first served partial");
        incr = 1'b1;
        for (int i = 11; i < 16; i++) if (seq[i] <= seq[i-1]) incr = 1'b0;
        check(incr, "R9", incr, 1, "lowest index first once all pending");
        distinct = 1'b1;
        for (int i = 0; i < 16; i++)
            for (int j = i + 1; j < 16; j++)
                if (seq[i] == seq[j]) distinct = 1'b0;
        check(distinct, "R8", distinct, 1, "each request served once in burst");
        mn = svc_n[0];
        mx = svc_n[0];
        for (int c = 1; c < NCH; c++) begin
            if (svc_n[c] < mn) mn = svc_n[c];
            if (svc_n[c] > mx) mx = svc_n[c];
        end
        check((mx - mn) <= 1, "R8", mx - mn, 1, "per-partial refresh counts agree");
        check(mn >= 28, "R8", mn, 28, "no lost requests");

        finish_run();
    end

endmodule